// File: doc/BRIEF.md
# Block-Form Burst Address Generator

This block turns one packed 32-bit memory descriptor into a stream of byte addresses for a local graphics memory that is organised as 8-byte blocks. Each bank holds 512 columns by 2048 rows of 64-bit blocks. A descriptor names a starting row and column. In the burst layout it also gives a block count, stored as the count minus one. The block emits one byte address per block on a valid/ready output channel. The address is eight times the combined {row, column} index.

Two packed layouts are accepted, and a select input chooses between them. The burst layout carries a 6-bit biased count and can describe up to 64 blocks (512 bytes). The direct-access layout spreads row and column over two 16-bit halves, has no count, and always names one block. A descriptor is taken only while the generator is idle. A one-cycle completion pulse follows the handshake of the final address.

Top module: `burst_addr_gen`

## Requirements
- R1: In the burst layout (`desc_fmt`=0) the column is `desc_word[8:0]` and the row is `desc_word[22:12]`. The first address is 8*(column + 512*row).
- R2: In the burst layout the count field `desc_word[29:24]` holds N-1, and exactly N addresses are handed over (field 0 gives 1, field 63 gives 64).
- R3: In the direct-access layout (`desc_fmt`=1) the column is `desc_word[8:0]` and the row is `desc_word[26:16]`. Exactly one address is handed over.
- R4: Each address after the first is 8 above its predecessor. A burst carries from column 511 into column 0 of the next row, and from the last block of the bank to address 0.
- R5: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_byte` and `addr_last` do not change.
- R6: `desc_ready` is high exactly when no burst is in progress. A descriptor presented while busy has no effect on the address stream.
- R7: `addr_last` is high only on the final address of a burst. `done` is high for exactly one cycle, the cycle after the final handshake.
- R8: Burst-layout bits 31:30, 23 and 11:9 do not affect the output.
- R9: After reset `desc_ready` is 1, and `addr_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Generator idle, descriptor will be taken |
| desc_fmt | input | 1 | 0 = burst layout, 1 = direct-access layout |
| desc_word | input | 32 | Packed descriptor |
| addr_valid | output | 1 | Byte address offered |
| addr_ready | input | 1 | Consumer takes the address |
| addr_byte | output | 23 | Byte address within one bank |
| addr_last | output | 1 | Current address is the final one of the burst |
| done | output | 1 | One-cycle pulse after the final handshake |

## Verification
On every cycle the assertions check four things:
- the address and last flag hold under backpressure;
- each accepted non-final address steps the index by exactly one;
- the final handshake leads to an idle state with a single done pulse;
- every accepted descriptor produces an address on the next cycle.

Field decoding cannot be seen from one cycle to the next, so the bench scenarios must show it. These scenarios cover the count bias, the row carry and bank wrap, the ignored spare bits, and a descriptor offered during a burst. The bench model predicts every output on every clock under both steady and irregular consumer readiness.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int DESC_W     = 32;
    localparam int COL_W      = 9;
    localparam int ROW_W      = 11;
    localparam int LEN_W      = 6;
    localparam int BLK_SHIFT  = 3;
    localparam int BF_ROW_LSB = 12;
    localparam int BF_LEN_LSB = 24;
    localparam int XF_ROW_LSB = 16;

    typedef enum logic {
        FMT_BURST  = 1'b0,
        FMT_DIRECT = 1'b1
    } desc_fmt_e;
endpackage

// File: rtl/bag_desc_decode.sv
module bag_desc_decode
    import bag_pkg::*;
#(
    parameter int DW      = DESC_W,
    parameter int CW      = COL_W,
    parameter int RW      = ROW_W,
    parameter int LW      = LEN_W,
    parameter int B_ROW   = BF_ROW_LSB,
    parameter int B_LEN   = BF_LEN_LSB,
    parameter int X_ROW   = XF_ROW_LSB,
    localparam int IW     = RW + CW
) (
    input  logic [DW-1:0] word_i,
    input  logic          fmt_i,
    output logic [IW-1:0] idx_o,
    output logic [LW-1:0] len_m1_o
);
    logic [CW-1:0] col_w;
    logic [RW-1:0] row_burst_w;
    logic [RW-1:0] row_direct_w;
    logic [LW-1:0] len_burst_w;
    logic          unused_bits_w;

    // Column sits at the bottom in both layouts
    assign col_w        = word_i[CW-1:0];
    assign row_burst_w  = word_i[B_ROW+RW-1:B_ROW];
    assign row_direct_w = word_i[X_ROW+RW-1:X_ROW];
    assign len_burst_w  = word_i[B_LEN+LW-1:B_LEN];

    // Spare bits of the burst layout carry no meaning
    assign unused_bits_w = ^{word_i[DW-1:B_LEN+LW], word_i[B_ROW-1:CW]};

    always_comb begin
        if (fmt_i == FMT_DIRECT) begin
            idx_o    = {row_direct_w, col_w};
            len_m1_o = '0;
        end else begin
            idx_o    = {row_burst_w, col_w};
            len_m1_o = len_burst_w;
        end
    end
endmodule

// File: rtl/bag_burst_walk.sv
module bag_burst_walk #(
    parameter int IW = 20,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [IW-1:0] start_idx_i,
    input  logic [LW-1:0] start_len_m1_i,
    input  logic          take_i,
    output logic          busy_o,
    output logic [IW-1:0] idx_o,
    output logic          last_o,
    output logic          done_o
);
    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [LW-1:0] rem;
        logic          done;
    } walk_t;

    walk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = start_idx_i;
                st_d.rem  = start_len_m1_i;
            end
        end else if (take_i) begin
            if (st_q.rem == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.rem = st_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign idx_o  = st_q.idx;
    assign last_o = st_q.busy && (st_q.rem == '0);
    assign done_o = st_q.done;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !take_i) |=> (busy_o && $stable(idx_o) && $stable(last_o))); // R5
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && take_i && !last_o) |=> (busy_o && idx_o == IW'($past(idx_o) + 1'b1))); // R4
    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && take_i && last_o) |=> (done_o && !busy_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int DW     = DESC_W,
    parameter int CW     = COL_W,
    parameter int RW     = ROW_W,
    parameter int LW     = LEN_W,
    parameter int SHIFT  = BLK_SHIFT,
    localparam int IW    = RW + CW,
    localparam int AW    = IW + SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_valid,
    output logic          desc_ready,
    input  logic          desc_fmt,
    input  logic [DW-1:0] desc_word,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic [AW-1:0] addr_byte,
    output logic          addr_last,
    output logic          done
);
    logic [IW-1:0] dec_idx_w;
    logic [LW-1:0] dec_len_w;
    logic [IW-1:0] cur_idx_w;
    logic          busy_w;
    logic          accept_w;

    bag_desc_decode #(
        .DW(DW), .CW(CW), .RW(RW), .LW(LW)
    ) u_decode (
        .word_i   (desc_word),
        .fmt_i    (desc_fmt),
        .idx_o    (dec_idx_w),
        .len_m1_o (dec_len_w)
    );

    assign desc_ready = !busy_w;
    assign accept_w   = desc_valid && desc_ready;

    bag_burst_walk #(
        .IW(IW), .LW(LW)
    ) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (accept_w),
        .start_idx_i    (dec_idx_w),
        .start_len_m1_i (dec_len_w),
        .take_i         (addr_ready),
        .busy_o         (busy_w),
        .idx_o          (cur_idx_w),
        .last_o         (addr_last),
        .done_o         (done)
    );

    assign addr_valid = busy_w;
    assign addr_byte  = {cur_idx_w, {SHIFT{1'b0}}};

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> (addr_valid && !desc_ready)); // R6
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid); // R7
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NIDX = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        desc_valid;
    logic        desc_ready;
    logic        desc_fmt;
    logic [31:0] desc_word;
    logic        addr_valid;
    logic        addr_ready;
    logic [22:0] addr_byte;
    logic        addr_last;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    // Behavioural reference state
    int m_busy = 0, m_idx = 0, m_rem = 0, m_done = 0;
    int hs_cnt = 0;
    bit rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_fmt(desc_fmt), .desc_word(desc_word),
        .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr_byte(addr_byte), .addr_last(addr_last), .done(done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_rem = 0; m_done = 0;
        end else begin
            if (addr_valid && addr_ready) hs_cnt++;
            m_done = 0;
            if (m_busy == 0) begin
                if (desc_valid) begin
                    m_busy = 1;
                    if (desc_fmt) begin
                        m_idx = (desc_word % 512) + 512 * ((desc_word >> 16) % 2048);
                        m_rem = 0;
                    end else begin
                        m_idx = (desc_word % 512) + 512 * ((desc_word >> 12) % 2048);
                        m_rem = (desc_word >> 24) % 64;
                    end
                end
            end else if (addr_ready) begin
                if (m_rem == 0) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_idx = (m_idx + 1) % NIDX;
                    m_rem--;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 desc_ready", desc_ready, m_busy == 0);
            check("R2 addr_valid", addr_valid, m_busy != 0);
            check("R7 done", done, m_done);
            if (m_busy != 0) begin
                check("R1/R4 addr_byte", addr_byte, longint'(m_idx) * 8);
                check("R7 addr_last", addr_last, m_rem == 0);
            end
        end
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        addr_ready <= rdy_rand ? lfsr[0] : 1'b1;
    end

    task automatic run_desc(input logic fmt, input logic [31:0] w, input int exp_n,
                            input string req, input bit poke_busy);
        int waited = 0;
        @(negedge clk);
        hs_cnt = 0;
        desc_fmt = fmt; desc_word = w; desc_valid = 1'b1;
        @(negedge clk);
        check({req, " first address"}, addr_byte,
              longint'((fmt ? ((w % 512) + 512 * ((w >> 16) % 2048))
                            : ((w % 512) + 512 * ((w >> 12) % 2048)))) * 8);
        if (poke_busy) begin
            desc_word = 32'h0FF0_1234; desc_fmt = 1'b0; // R6: offered while busy
            @(negedge clk);
            @(negedge clk);
        end
        desc_valid = 1'b0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check({req, " done seen"}, done, 1);
        check({req, " handshake count"}, hs_cnt, exp_n);
    endtask

    initial begin
        rst_n = 1'b0; desc_valid = 1'b0; desc_fmt = 1'b0; desc_word = '0;
        repeat (3) @(negedge clk);
        check("R9 reset desc_ready", desc_ready, 1);
        check("R9 reset addr_valid", addr_valid, 0);
        check("R9 reset done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: single block, then max-length burst
        run_desc(1'b0, 32'h0000_5007, 1, "R2 len0", 1'b0);
        run_desc(1'b0, 32'h3F00_3010, 64, "R2 len63", 1'b0);
        // R4: carry from column 511 into next row
        run_desc(1'b0, {8'h05, 1'b0, 11'd7, 3'b000, 9'd509}, 6, "R4 row carry", 1'b0);
        // R4: wrap at end of bank
        run_desc(1'b0, {8'h03, 1'b0, 11'd2047, 3'b000, 9'd510}, 4, "R4 bank wrap", 1'b0);
        // R3: direct layout, count bits ignored
        run_desc(1'b1, {5'b11111, 11'd1234, 7'h7F, 9'd321}, 1, "R3 direct", 1'b0);
        // R8: spare bits set
        run_desc(1'b0, {2'b11, 6'd2, 1'b1, 11'd100, 3'b111, 9'd5}, 3, "R8 spare bits", 1'b0);
        // R5: irregular consumer readiness
        rdy_rand = 1'b1;
        run_desc(1'b0, 32'h1F12_3456, 32, "R5 stall", 1'b0);
        run_desc(1'b1, 32'h07FF_01FF, 1, "R5 R3 direct stall", 1'b0);
        // R6: descriptor offered while busy is ignored
        run_desc(1'b0, 32'h0A00_2100, 11, "R6 busy poke", 1'b1);
        rdy_rand = 1'b0;
        for (int k = 0; k < 8; k++) begin
            run_desc(1'(k % 2), 32'h0100_0000 * (k * 7) + 32'h0001_3000 * k + 32'(k * 63),
                     (k % 2) ? 1 : ((k * 7) % 64) + 1, "R1 sweep", 1'b0);
        end
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule